// File: doc/BRIEF.md
# Raster Line-Position Interrupt Generator

This block belongs to a video timing engine. A free-running pixel counter walks every frame in scan order, through sync, porch and active regions alike. Software names an active line (counting from 1), and the block turns that line number into a pixel index within the frame. When the counter reaches that index, a sticky status bit is raised. An interrupt line is driven while that status bit is set and its enable bit is also set.

The horizontal and vertical timing values are static inputs from the timing engine's configuration. A single-cycle write strobe with a byte address reaches four registers. Interrupt enable sits at 0x1C0, pending status at 0x1C4, write-one-to-clear at 0x1C8, and the line compare at 0x250. Reading the compare register returns the converted pixel index, not the line number that was written. The line event uses bit 8 of the enable, status and clear registers. In 4:2:0 output mode every horizontal quantity is halved before any position is derived.

Top module: `line_pos_irq`

## Requirements
- R1: The pixel counter is 0 in the first cycle after reset. It then advances by one per clock and returns to 0 after reaching frame_lines × hperiod − 1. Here hperiod = hsync + hback + hactive + hfront, and frame_lines = vsync + vback + vactive + vfront.
- R2: Writing line N, with 1 ≤ N ≤ vactive, to 0x250 loads the compare with (vsync + vback) × hperiod + hskew + (N − 1) × hperiod. Reading 0x250 returns that value.
- R3: Writing 0 to 0x250 loads 0xFFFFFFFF, and no line event then occurs.
- R4: Writing a value greater than vactive to 0x250 leaves the compare unchanged. All 32 bits of the written word are considered.
- R5: Status bit 8 (0x1C4) becomes 1 on the clock edge after the cycle in which the counter equals the compare.
- R6: Writing 0x1C8 with bit 8 set clears status bit 8. Writing it with bit 8 clear leaves status unchanged.
- R7: line_irq_o is high exactly when status bit 8 and enable bit 8 are both 1. Status stays set while enable is 0.
- R8: A write to 0x1C0 that turns enable bit 8 from 0 to 1 also clears status bit 8 in the same edge.
- R9: If a line event and a status-clearing write (a clear write or an arming enable write) land on the same edge, status ends up set.
- R10: A new compare value is used from the next cycle, inside the current frame.
- R11: With yuv420_i high, hsync, hback, hactive, hfront and hskew are each shifted right by one before the period, frame length and compare are derived.
- R12: After reset, enable and status read 0 and the compare reads 0xFFFFFFFF.
- R13: Enable bit 8 reads back as written. All other bits of 0x1C0 and 0x1C4 read 0, and 0x1C8 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| yuv420_i | input | 1 | Halve the horizontal timing (4:2:0 output) |
| hsync_w_i | input | 12 | Horizontal sync width, pixels |
| hbp_i | input | 12 | Horizontal back porch, pixels |
| hact_i | input | 12 | Active width, pixels |
| hfp_i | input | 12 | Horizontal front porch, pixels |
| hskew_i | input | 12 | Horizontal skew, pixels |
| vsync_w_i | input | 12 | Vertical sync width, lines |
| vbp_i | input | 12 | Vertical back porch, lines |
| vact_i | input | 12 | Active height, lines |
| vfp_i | input | 12 | Vertical front porch, lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| line_irq_o | output | 1 | Line interrupt |

## Verification
Every cycle, the embedded properties check the following: the counter steps by one or wraps to zero, a line event always leaves status set, and a clear or an arming write without a coincident event leaves it clear. They also check that a rejected line write leaves the compare unchanged, that line 0 loads all ones, and that the interrupt stays low while the enable is off. The bench scenarios are needed for the arithmetic and the timing. These cover the converted pixel index with and without 4:2:0 halving, the exact counter value at which the interrupt rises, the frame length between two events, that a mid-frame compare update takes effect within that frame, and a clear write placed precisely on the event cycle.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
    localparam int H_W    = 12;
    localparam int V_W    = 12;
    localparam int POS_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int LINE_BIT = 8;

    localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(12'h1C0);
    localparam logic [ADDR_W-1:0] ADDR_ISTS = ADDR_W'(12'h1C4);
    localparam logic [ADDR_W-1:0] ADDR_ICLR = ADDR_W'(12'h1C8);
    localparam logic [ADDR_W-1:0] ADDR_LCMP = ADDR_W'(12'h250);

    typedef struct packed {
        logic [H_W-1:0] sync;
        logic [H_W-1:0] bp;
        logic [H_W-1:0] act;
        logic [H_W-1:0] fp;
        logic [H_W-1:0] skew;
    } htiming_t;

    typedef struct packed {
        logic [V_W-1:0] sync;
        logic [V_W-1:0] bp;
        logic [V_W-1:0] act;
        logic [V_W-1:0] fp;
    } vtiming_t;

    function automatic logic [POS_W-1:0] ext_h(logic [H_W-1:0] x);
        return {{(POS_W-H_W){1'b0}}, x};
    endfunction

    function automatic logic [POS_W-1:0] ext_v(logic [V_W-1:0] x);
        return {{(POS_W-V_W){1'b0}}, x};
    endfunction

    // 4:2:0 output runs the horizontal raster at half rate
    function automatic htiming_t scale_h(htiming_t h, logic half);
        htiming_t r;
        r = h;
        if (half) begin
            r.sync = h.sync >> 1;
            r.bp   = h.bp   >> 1;
            r.act  = h.act  >> 1;
            r.fp   = h.fp   >> 1;
            r.skew = h.skew >> 1;
        end
        return r;
    endfunction

    function automatic logic [POS_W-1:0] h_period(htiming_t h);
        return ext_h(h.sync) + ext_h(h.bp) + ext_h(h.act) + ext_h(h.fp);
    endfunction

    function automatic logic [POS_W-1:0] frame_lines(vtiming_t v);
        return ext_v(v.sync) + ext_v(v.bp) + ext_v(v.act) + ext_v(v.fp);
    endfunction

    // pixel index of active line n (1-based)
    function automatic logic [POS_W-1:0] line_to_pos(htiming_t h, vtiming_t v,
                                                     logic [POS_W-1:0] hp,
                                                     logic [V_W-1:0] n);
        logic [POS_W-1:0] lead;
        lead = ext_v(v.sync) + ext_v(v.bp);
        return lead * hp + ext_h(h.skew) + hp * (ext_v(n) - POS_W'(1));
    endfunction
endpackage

// File: rtl/lpi_raster.sv
module lpi_raster
    import lpi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] total_i,
    output logic [POS_W-1:0] pix_o
);
    logic [POS_W-1:0] pix_q;

    always_ff @(posedge clk) begin
        if (rst)
            pix_q <= '0;
        else if (pix_q >= total_i - POS_W'(1))
            pix_q <= '0;
        else
            pix_q <= pix_q + POS_W'(1);
    end

    assign pix_o = pix_q;

    // R1
    step_or_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_q != '1) |=> ((pix_q == $past(pix_q) + POS_W'(1)) || (pix_q == '0)));
endmodule

// File: rtl/lpi_cmp.sv
module lpi_cmp
    import lpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  htiming_t          h_i,
    input  vtiming_t          v_i,
    input  logic [POS_W-1:0]  hper_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] line_i,
    output logic [POS_W-1:0]  cmp_o
);
    logic [POS_W-1:0]  cmp_q;
    logic [DATA_W-1:0] act_ext;
    logic              too_far;

    assign act_ext = {{(DATA_W-V_W){1'b0}}, v_i.act};
    assign too_far = line_i > act_ext;

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '1;
        else if (we_i) begin
            if (line_i == '0)
                cmp_q <= '1;
            else if (!too_far)
                cmp_q <= line_to_pos(h_i, v_i, hper_i, line_i[V_W-1:0]);
        end
    end

    assign cmp_o = cmp_q;

    // R4
    reject_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && too_far) |=> $stable(cmp_q));
    // R3
    zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && line_i == '0) |=> (&cmp_q));
endmodule

// File: rtl/lpi_regs.sv
module lpi_regs
    import lpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wbit_i,
    input  logic              hit_i,
    output logic              en_o,
    output logic              st_o,
    output logic              irq_o
);
    logic en_q, st_q;
    logic en_wr, clr_wr, arm;

    assign en_wr  = we_i && (addr_i == ADDR_IEN);
    assign clr_wr = we_i && (addr_i == ADDR_ICLR) && wbit_i;
    assign arm    = en_wr && wbit_i && !en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            st_q <= 1'b0;
        end else begin
            if (en_wr)
                en_q <= wbit_i;
            if (hit_i)
                st_q <= 1'b1;
            else if (clr_wr || arm)
                st_q <= 1'b0;
        end
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign irq_o = en_q & st_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> st_q);
    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADDR_ICLR && wbit_i && !hit_i) |=> !st_q);
    // R8
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADDR_IEN && wbit_i && !en_o && !hit_i) |=> !st_q);
    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q && !(we_i && wbit_i && (addr_i == ADDR_ICLR || addr_i == ADDR_IEN))) |=> st_q);
endmodule

// File: rtl/line_pos_irq.sv
module line_pos_irq
    import lpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              yuv420_i,
    input  logic [H_W-1:0]    hsync_w_i,
    input  logic [H_W-1:0]    hbp_i,
    input  logic [H_W-1:0]    hact_i,
    input  logic [H_W-1:0]    hfp_i,
    input  logic [H_W-1:0]    hskew_i,
    input  logic [V_W-1:0]    vsync_w_i,
    input  logic [V_W-1:0]    vbp_i,
    input  logic [V_W-1:0]    vact_i,
    input  logic [V_W-1:0]    vfp_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              line_irq_o
);
    htiming_t         h_raw, h_eff;
    vtiming_t         v_cfg;
    logic [POS_W-1:0] hper, total, pix, cmp;
    logic             hit, en_line, st_line, cmp_we;

    assign h_raw = htiming_t'{sync: hsync_w_i, bp: hbp_i, act: hact_i,
                              fp: hfp_i, skew: hskew_i};
    assign v_cfg = vtiming_t'{sync: vsync_w_i, bp: vbp_i, act: vact_i, fp: vfp_i};
    assign h_eff = scale_h(h_raw, yuv420_i);
    assign hper  = h_period(h_eff);
    assign total = frame_lines(v_cfg) * hper;

    lpi_raster u_raster (
        .clk     (clk),
        .rst     (rst),
        .total_i (total),
        .pix_o   (pix)
    );

    assign cmp_we = reg_we_i && (reg_addr_i == ADDR_LCMP);

    lpi_cmp u_cmp (
        .clk    (clk),
        .rst    (rst),
        .h_i    (h_eff),
        .v_i    (v_cfg),
        .hper_i (hper),
        .we_i   (cmp_we),
        .line_i (reg_wdata_i),
        .cmp_o  (cmp)
    );

    assign hit = (pix == cmp);

    lpi_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we_i   (reg_we_i),
        .addr_i (reg_addr_i),
        .wbit_i (reg_wdata_i[LINE_BIT]),
        .hit_i  (hit),
        .en_o   (en_line),
        .st_o   (st_line),
        .irq_o  (line_irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_IEN:  reg_rdata_o[LINE_BIT] = en_line;
            ADDR_ISTS: reg_rdata_o[LINE_BIT] = st_line;
            ADDR_LCMP: reg_rdata_o = DATA_W'(cmp);
            default:   reg_rdata_o = '0;
        endcase
    end

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !en_line |-> !line_irq_o);
endmodule

// File: tb/test_line_pos_irq.sv
module test_line_pos_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        yuv = 1'b0;
    logic [11:0] hs = 12'd2, hb = 12'd3, ha = 12'd8, hf = 12'd2, sk = 12'd1;
    logic [11:0] vs = 12'd1, vb = 12'd2, va = 12'd6, vf = 12'd1;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    localparam logic [11:0] A_EN = 12'h1C0, A_ST = 12'h1C4, A_CL = 12'h1C8, A_CMP = 12'h250;
    localparam logic [31:0] B8 = 32'h100;

    int n_chk = 0, n_fail = 0, cyc = 0, tb_pix = 0, last_rise = 0;
    bit done = 0, prev_irq = 0;
    int exp_pos_q[$];
    string exp_req_q[$];

    always #10 clk = ~clk;

    line_pos_irq i_line_pos_irq (
        .clk(clk), .rst(rst), .yuv420_i(yuv),
        .hsync_w_i(hs), .hbp_i(hb), .hact_i(ha), .hfp_i(hf), .hskew_i(sk),
        .vsync_w_i(vs), .vbp_i(vb), .vact_i(va), .vfp_i(vf),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .line_irq_o(irq)
    );

    function automatic int hdiv(logic [11:0] x);
        return yuv ? int'(x >> 1) : int'(x);
    endfunction
    function automatic int hper_m();
        return hdiv(hs) + hdiv(hb) + hdiv(ha) + hdiv(hf);
    endfunction
    function automatic int total_m();
        return (int'(vs) + int'(vb) + int'(va) + int'(vf)) * hper_m();
    endfunction

    // reference raster model from R1
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) tb_pix <= 0;
        else if (tb_pix >= total_m() - 1) tb_pix <= 0;
        else tb_pix <= tb_pix + 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each interrupt rise must match the next expected position
    always @(negedge clk) begin
        if (rst) prev_irq = 0;
        else begin
            if (irq && !prev_irq) begin
                last_rise = cyc;
                n_chk++;
                if (exp_pos_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5 unexpected rise actual=%0d expected=none", tb_pix);
                end else begin
                    int p;
                    string r;
                    p = exp_pos_q.pop_front();
                    r = exp_req_q.pop_front();
                    if (tb_pix != p) begin
                        n_fail++;
                        $display("FAIL %s rise at pixel actual=%0d expected=%0d", r, tb_pix, p);
                    end
                end
            end
            prev_irq = irq;
        end
    end

    task automatic push(int pos, string req);
        exp_pos_q.push_back(pos);
        exp_req_q.push_back(req);
    endtask

    task automatic drain(string req);
        for (int i = 0; i < 400 && exp_pos_q.size() != 0; i++) @(negedge clk);
        n_chk++;
        if (exp_pos_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing rise actual=none expected=%0d", req, exp_pos_q[0]);
            exp_pos_q.delete();
            exp_req_q.delete();
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_pix(int p);
        @(negedge clk);
        while (tb_pix != p) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int t0, t1;
        do_reset();

        // R12 reset state
        rd(A_EN, v);  chk("R12 enable", v, 0);
        rd(A_ST, v);  chk("R12 status", v, 0);
        rd(A_CMP, v); chk("R12 compare", v, 32'hFFFF_FFFF);
        chk("R12 irq", {31'b0, irq}, 0);

        // R2 line 1: 3*15+1 = 46
        wr(A_CMP, 1); rd(A_CMP, v); chk("R2 line1", v, 46);
        wr(A_EN, B8); rd(A_EN, v); chk("R13 enable readback", v, B8);
        rd(A_CL, v); chk("R13 clear reads zero", v, 0);
        push(47, "R5"); drain("R5");
        wr(A_EN, 0);
        rd(A_ST, v); chk("R5 status set", v, B8);
        wr(A_CL, 32'h1); rd(A_ST, v); chk("R6 zero bit keeps", v, B8);
        wr(A_CL, B8); rd(A_ST, v); chk("R6 clear", v, 0);

        // R2 last line: 46+75 = 121; R4 rejects
        wr(A_CMP, 6); rd(A_CMP, v); chk("R2 line6", v, 121);
        wr(A_CMP, 7); rd(A_CMP, v); chk("R4 over height", v, 121);
        wr(A_CMP, 32'h0001_0002); rd(A_CMP, v); chk("R4 high bits", v, 121);

        // R10 mid-frame update: line 4 = 91, written after pixel 50
        wait_pix(50);
        t0 = cyc;
        wr(A_CMP, 4);
        wr(A_EN, B8);
        push(92, "R10"); drain("R10");
        chk("R10 same frame", {31'b0, (last_rise - t0) < 60 && last_rise > t0}, 1);
        wr(A_EN, 0);

        // R3 line 0 disables
        wr(A_CMP, 0); rd(A_CMP, v); chk("R3 all ones", v, 32'hFFFF_FFFF);
        wr(A_EN, B8);
        repeat (320) @(negedge clk);
        rd(A_ST, v); chk("R3 no event", v, 0);
        chk("R3 irq low", {31'b0, irq}, 0);
        wr(A_EN, 0);

        // R7 sticky while masked, line 2 = 61
        wr(A_CMP, 2); rd(A_CMP, v); chk("R2 line2", v, 61);
        wr(A_CL, B8);
        repeat (160) @(negedge clk);
        rd(A_ST, v); chk("R7 sticky masked", v, B8);
        chk("R7 irq masked", {31'b0, irq}, 0);

        // R8 arming clears stale status
        wait_pix(100);
        wr(A_EN, B8);
        rd(A_ST, v); chk("R8 arm clears", v, 0);
        push(62, "R8"); drain("R8");
        wr(A_EN, 0);

        // R9 clear on the event edge
        wait_pix(80);
        wr(A_CL, B8);
        rd(A_ST, v); chk("R9 pre-clear", v, 0);
        wait_pix(61);
        we = 1'b1; addr = A_CL; wdata = B8;
        @(negedge clk);
        we = 1'b0;
        rd(A_ST, v); chk("R9 set wins", v, B8);

        // R11 4:2:0 halving: hper 7, lead 21, skew 0, frame 70
        yuv = 1'b1;
        do_reset();
        wr(A_CMP, 1); rd(A_CMP, v); chk("R11 line1", v, 21);
        wr(A_CMP, 6); rd(A_CMP, v); chk("R11 line6", v, 56);

        // R1 frame length between two events
        wr(A_EN, B8);
        push(57, "R11"); drain("R11");
        t0 = last_rise;
        wr(A_CL, B8);
        push(57, "R1"); drain("R1");
        t1 = last_rise;
        chk("R1 frame period", t1 - t0, 70);
        wr(A_EN, 0);

        finish_run();
    end
endmodule